// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an asynchronous static RAM. The host asks for one word at a time: it raises a request with a direction bit, an address and, for a write, a data word. The block then drives the memory's active-low chip select, output enable and write strobe, its address lines and a shared data bus, in the order the memory needs. For a read it returns the captured word with a one-cycle valid strobe. For a write it returns a one-cycle done strobe.

Every phase is a whole number of clock cycles. Each count is found by ceiling division of a nanosecond minimum by the clock-period parameter, so the same design meets the memory's timing at any clock rate. Writes are framed by the overlap of chip select and write strobe. Output enable stays high for the whole write. The data bus is driven only during the write and for one hold cycle after it. After a read, a recovery phase lets the memory's outputs float before the bus can be driven again.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, `ready` is 1, the three strobes are high, `rd_valid` and `wr_done` are 0, and the data bus is released.
- R2: A request is taken only when `ready` is 1. A request that is held while the block is busy has no effect on the memory contents or on the returned data.
- R3: A read (`req_we`=0) holds chip select and output enable low, with a steady address, for RD = ceil(max(12,12,5) ns / CLK_NS) cycles. At the last edge of that phase the bus is captured into `rd_data`, and `rd_valid` pulses for one cycle RD+1 rising edges after the edge at which the request was taken.
- R4: After a read, `ready` returns only after REC = ceil(5 ns / CLK_NS) further cycles, so the memory has released the bus before the block can drive it.
- R5: A write (`req_we`=1) holds chip select and the write strobe low for WR = ceil(max(8,8,8,7) ns / CLK_NS) cycles, with output enable high throughout. Each strobe's low time is at least WR cycles.
- R6: The block drives the data bus only during the write phase and the one hold cycle after it, and never while output enable is low.
- R7: A write takes WR plus WH cycles, where WH = max(1, ceil(12 ns / CLK_NS) - WR). `wr_done` pulses for one cycle 1+WR+WH rising edges after the request edge, together with `ready` returning to 1.
- R8: Output enable and the write strobe are never low together, and the write strobe is low only while chip select is low.
- R9: The address does not change while chip select is low.
- R10: All phase lengths come from the CLK_NS parameter by ceiling division, and none is shorter than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Host request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| ready | output | 1 | Block is idle and will accept a request |
| rd_data | output | DW | Captured read word |
| rd_valid | output | 1 | One-cycle strobe: `rd_data` is new |
| wr_done | output | 1 | One-cycle strobe: write finished |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_addr | output | AW | Memory address |
| sram_dq | inout | DW | Memory data bus |

## Verification
On every cycle the assertions check the strobe relations: output enable never overlaps the write strobe, the write strobe is low only inside chip select, the bus is driven only while output enable is high, the address is steady under chip select, and the write strobe's low time is long enough. The nanosecond timing itself, the absence of contention during the memory's turn-off delay, the returned data and the fact that a request made while busy is ignored can only be shown by the bench. It does this with a behavioural memory that times every edge against the minimums and a scoreboard that follows every write.

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl #(
  parameter int CLK_NS = 10,
  parameter int AW     = 18,
  parameter int DW     = 16,
  parameter int T_RC   = 12,
  parameter int T_AA   = 12,
  parameter int T_DOE  = 5,
  parameter int T_HZOE = 5,
  parameter int T_WC   = 12,
  parameter int T_PWE  = 8,
  parameter int T_SCE  = 8,
  parameter int T_AW   = 8,
  parameter int T_SD   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          wr_done,
  output logic          sram_ce_n,
  output logic          sram_oe_n,
  output logic          sram_we_n,
  output logic [AW-1:0] sram_addr,
  inout  wire  [DW-1:0] sram_dq
);
  localparam int RD_NS  = (T_RC > T_AA ? (T_RC > T_DOE ? T_RC : T_DOE) : (T_AA > T_DOE ? T_AA : T_DOE));
  localparam int WR_A   = (T_PWE > T_SCE) ? T_PWE : T_SCE;
  localparam int WR_B   = (T_AW > T_SD) ? T_AW : T_SD;
  localparam int WR_NS  = (WR_A > WR_B) ? WR_A : WR_B;
  localparam int RD_RAW = (RD_NS + CLK_NS - 1) / CLK_NS;
  localparam int RC_RAW = (T_HZOE + CLK_NS - 1) / CLK_NS;
  localparam int WR_RAW = (WR_NS + CLK_NS - 1) / CLK_NS;
  localparam int WC_CYC = (T_WC + CLK_NS - 1) / CLK_NS;
  // R10
  localparam int RD_CYC  = (RD_RAW < 1) ? 1 : RD_RAW;
  localparam int REC_CYC = (RC_RAW < 1) ? 1 : RC_RAW;
  localparam int WR_CYC  = (WR_RAW < 1) ? 1 : WR_RAW;
  localparam int WH_CYC  = (WC_CYC > WR_CYC + 1) ? WC_CYC - WR_CYC : 1;
  localparam int MAXC    = (RD_CYC > WR_CYC ? RD_CYC : WR_CYC) + REC_CYC + WH_CYC;
  localparam int CW      = $clog2(MAXC + 1) + 1;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_REC, S_WR, S_WH} state_t;
  state_t        st;
  logic [CW-1:0] cnt;
  logic          drv;
  logic [DW-1:0] wd_q;

  assign ready   = (st == S_IDLE);
  assign sram_dq = drv ? wd_q : {DW{1'bz}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      drv <= 1'b0;
      wd_q <= '0;
      sram_addr <= '0;
      rd_data <= '0;
      rd_valid <= 1'b0;
      wr_done <= 1'b0;
      sram_ce_n <= 1'b1;
      sram_oe_n <= 1'b1;
      sram_we_n <= 1'b1;
    end else begin
      rd_valid <= 1'b0;
      wr_done  <= 1'b0;
      unique case (st)
        S_IDLE: if (req) begin
          sram_addr <= req_addr;
          wd_q      <= req_wdata;
          sram_ce_n <= 1'b0;
          cnt       <= '0;
          if (req_we) begin
            sram_we_n <= 1'b0;
            drv       <= 1'b1;
            st        <= S_WR;
          end else begin
            sram_oe_n <= 1'b0;
            st        <= S_RD;
          end
        end
        S_RD: if (cnt == CW'(RD_CYC - 1)) begin
          rd_data   <= sram_dq;
          rd_valid  <= 1'b1;
          sram_ce_n <= 1'b1;
          sram_oe_n <= 1'b1;
          cnt       <= '0;
          st        <= S_REC;
        end else cnt <= cnt + 1'b1;
        S_REC: if (cnt == CW'(REC_CYC - 1)) st <= S_IDLE;
               else cnt <= cnt + 1'b1;
        S_WR: if (cnt == CW'(WR_CYC - 1)) begin
          sram_ce_n <= 1'b1;
          sram_we_n <= 1'b1;
          cnt       <= '0;
          st        <= S_WH;
        end else cnt <= cnt + 1'b1;
        S_WH: if (cnt == CW'(WH_CYC - 1)) begin
          drv     <= 1'b0;
          wr_done <= 1'b1;
          st      <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] we_low_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) we_low_cnt <= '0;
    else if (!sram_we_n) we_low_cnt <= we_low_cnt + 1'b1;
    else we_low_cnt <= '0;

  // R8
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_oe_n && !sram_we_n));
  // R8
  we_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n);
  // R6
  no_contend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> $isunknown(sram_dq) || !drv);
  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));
  // R5
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_low_cnt >= CW'(WR_CYC)));
  // R3
  rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(!sram_ce_n && !sram_oe_n, 2));
  // R7
  wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_done) |-> sram_we_n && $past(sram_we_n) && ready);
endmodule

// File: tb/test_sram_seq_ctrl.sv
`timescale 1ns/1ps
module test_sram_seq_ctrl;
  localparam int CLK = 4;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int E_RD  = (12 + CLK - 1) / CLK;
  localparam int E_REC = (5 + CLK - 1) / CLK;
  localparam int E_WR  = (8 + CLK - 1) / CLK;
  localparam int E_WH  = ((12 + CLK - 1) / CLK > E_WR + 1) ? (12 + CLK - 1) / CLK - E_WR : 1;

  logic clk = 0, rst_n = 0;
  logic req = 0, req_we = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic ready, rd_valid, wr_done, ce_n, oe_n, we_n;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] maddr;
  wire  [DW-1:0] dq;

  always #(CLK/2.0) clk = ~clk;

  sram_seq_ctrl #(.CLK_NS(CLK), .AW(AW), .DW(DW)) i_sram_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .wr_done(wr_done), .sram_ce_n(ce_n), .sram_oe_n(oe_n), .sram_we_n(we_n),
    .sram_addr(maddr), .sram_dq(dq));

  int checks = 0, errors = 0;
  bit done_flag = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural memory
  logic [DW-1:0] mem [256];
  logic [DW-1:0] sb  [256];
  function automatic logic [DW-1:0] pat(input int i);
    return {i[7:0], ~i[7:0]};
  endfunction
  logic mem_en, mem_en_d = 0;
  assign mem_en = !ce_n && !oe_n && we_n;
  always @(mem_en) if (mem_en) mem_en_d = 1; else mem_en_d <= #5 1'b0;
  assign dq = mem_en_d ? mem[maddr] : {DW{1'bz}};

  realtime t_ce = 0, t_oe = 0, t_we = 0, t_ad = 0, t_dq = 0;
  always @(negedge ce_n) t_ce = $realtime;
  always @(negedge oe_n) t_oe = $realtime;
  always @(negedge we_n) t_we = $realtime;
  always @(maddr) t_ad = $realtime;
  always @(dq) t_dq = $realtime;
  wire wr_act = !ce_n && !we_n;
  wire rd_act = mem_en;
  always @(negedge wr_act) if (rst_n) begin
    chk($realtime - t_we >= 8, "R5 we pulse ns", int'($realtime - t_we), 8);
    chk($realtime - t_ce >= 8, "R5 ce to write end ns", int'($realtime - t_ce), 8);
    chk($realtime - t_ad >= 8, "R9 addr setup ns", int'($realtime - t_ad), 8);
    chk($realtime - t_dq >= 7, "R6 data setup ns", int'($realtime - t_dq), 7);
    chk(!$isunknown(dq), "R6 write data known", 0, 0);
    mem[maddr] = dq;
  end
  always @(negedge rd_act) if (rst_n) begin
    chk($realtime - t_ce >= 12, "R3 ce read ns", int'($realtime - t_ce), 12);
    chk($realtime - t_ad >= 12, "R3 addr access ns", int'($realtime - t_ad), 12);
    chk($realtime - t_oe >= 5, "R3 oe access ns", int'($realtime - t_oe), 5);
  end
  always @(negedge clk) if (rst_n && mem_en_d && dq !== mem[maddr])
    chk(0, "R6 bus contention", int'(dq), int'(mem[maddr]));

  // op: request, optionally hammer while busy, measure latency
  task automatic do_op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit hammer, output int lat, output logic [DW-1:0] rd);
    int n = 0;
    @(negedge clk);
    req = 1; req_we = w; req_addr = a; req_wdata = d;
    lat = -1; rd = '0;
    while (lat < 0 && n < 50) begin
      @(negedge clk); n++;
      if (n == 1) begin
        if (hammer) begin req_we = 1; req_addr = a ^ 8'h01; req_wdata = 16'hDEAD; if (w) req_addr = a; end
        else req = 0;
        if (w) chk(dq === d && oe_n && !we_n && !ce_n, "R5 write strobes and bus", int'(dq), int'(d));
        else chk(!oe_n && !ce_n && we_n, "R3 read strobes", int'({ce_n, oe_n, we_n}), 1);
      end
      if (n == 3) req = 0;
      if (w ? wr_done : rd_valid) begin lat = n; rd = rd_data; end
    end
    if (w) chk(ready === 1'b1, "R7 ready with wr_done", int'(ready), 1);
    else begin
      int k = 0;
      while (!ready && k < 20) begin @(negedge clk); k++; end
      chk(k == E_REC, "R4 read recovery cycles", k, E_REC);
    end
  endtask

  typedef logic [24:0] vec_t;
  localparam vec_t VEC [12] = '{
    {1'b1, 8'h10, 16'h1234}, {1'b0, 8'h10, 16'h0000}, {1'b0, 8'h11, 16'h0000},
    {1'b1, 8'hFF, 16'hFFFF}, {1'b1, 8'h00, 16'h0000}, {1'b0, 8'hFF, 16'h0000},
    {1'b0, 8'h00, 16'h0000}, {1'b1, 8'h10, 16'hA5A5}, {1'b1, 8'h11, 16'h5A5A},
    {1'b0, 8'h10, 16'h0000}, {1'b0, 8'h11, 16'h0000}, {1'b0, 8'h80, 16'h0000}};

  initial begin
    #(200000 * CLK);
    chk(0, "watchdog", 0, 1);
    if (!done_flag) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [DW-1:0] rd;
    for (int i = 0; i < 256; i++) begin mem[i] = pat(i); sb[i] = pat(i); end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ready === 1'b1, "R1 ready", int'(ready), 1);
    chk({ce_n, oe_n, we_n} === 3'b111, "R1 strobes", int'({ce_n, oe_n, we_n}), 7);
    chk(rd_valid === 1'b0 && wr_done === 1'b0, "R1 strobes out", int'({rd_valid, wr_done}), 0);
    chk(dq === {DW{1'bz}}, "R1 bus released", int'(dq), 0);
    rst_n = 1;
    for (int v = 0; v < 12; v++) begin
      do_op(VEC[v][24], VEC[v][23:16], VEC[v][15:0], 0, lat, rd);
      if (VEC[v][24]) begin
        sb[VEC[v][23:16]] = VEC[v][15:0];
        chk(lat == 1 + E_WR + E_WH, "R7 write latency", lat, 1 + E_WR + E_WH);
      end else begin
        chk(rd === sb[VEC[v][23:16]], "R3 read data", int'(rd), int'(sb[VEC[v][23:16]]));
        chk(lat == 1 + E_RD, "R3 R10 read latency", lat, 1 + E_RD);
      end
    end
    // R2: request held during a write must not repeat the write with new data
    do_op(1, 8'h20, 16'hBEEF, 1, lat, rd);
    sb[8'h20] = 16'hBEEF;
    @(negedge clk);
    chk(ready === 1'b1 && ce_n === 1'b1, "R2 no second accept", int'(ce_n), 1);
    do_op(0, 8'h20, 0, 0, lat, rd);
    chk(rd === 16'hBEEF, "R2 held request ignored (write)", int'(rd), 16'hBEEF);
    // R2: write request held during a read is ignored
    do_op(0, 8'h30, 0, 1, lat, rd);
    chk(rd === sb[8'h30], "R2 read data under hammer", int'(rd), int'(sb[8'h30]));
    do_op(0, 8'h31, 0, 0, lat, rd);
    chk(rd === sb[8'h31], "R2 held request ignored (read)", int'(rd), int'(sb[8'h31]));
    // back-to-back write right after read: recovery before drive (R4 R6)
    do_op(0, 8'h40, 0, 0, lat, rd);
    do_op(1, 8'h40, 16'h0F0F, 0, lat, rd);
    sb[8'h40] = 16'h0F0F;
    do_op(0, 8'h40, 0, 0, lat, rd);
    chk(rd === 16'h0F0F, "R4 write after read", int'(rd), 16'h0F0F);
    repeat (4) @(negedge clk);
    chk(ready && ce_n && oe_n && we_n && dq === {DW{1'bz}}, "R6 idle bus released", int'(dq), 0);
    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule